// File: doc/BRIEF.md
# Packed Predictor Table Proxy

This block sits between a spatial-pattern prefetch engine and the L2 cache. It gives the engine access to a large set-associative pattern table. The table is kept in a reserved range of physical memory: 1024 sets of 64 bytes per core, which the caches handle as ordinary data. Each request carries a trigger PC, the block offset inside a 32-block spatial region and, for an update, a new 32-bit pattern. The proxy answers with a hit flag and a pattern.

A small on-chip store holds eight whole table sets. A request whose set is already held is served locally. Otherwise the proxy works out the set's memory address, optionally writes back a dirty victim, and reads the packed 64-byte block through a valid/ready request port. The response port has no fixed latency. The proxy then unpacks the eleven entries and serves the request.

The controller is a state machine with these states:
- ST_IDLE accepts a request and moves to ST_PROBE.
- ST_PROBE moves to ST_SERVE when the set is held on chip.
- Otherwise ST_PROBE moves to ST_WRBACK when the round-robin victim slot is valid and dirty, and to ST_FILLREQ when it is not.
- ST_WRBACK moves to ST_FILLREQ when the memory port is ready.
- ST_FILLREQ moves to ST_FILLWAIT when the memory port is ready.
- ST_FILLWAIT moves to ST_SERVE when the memory response arrives.
- ST_SERVE always moves to ST_RESP.
- ST_RESP always moves to ST_IDLE.

Top module: `pv_table_proxy`

## Requirements
- R1: The 21-bit index is {req_pc, req_off}. Index bits 9:0 select the table set and bits 20:10 form the 11-bit entry tag.
- R2: Way i of a packed 512-bit block occupies bits 43*i+42 down to 43*i. The tag is in the low 11 bits of that field and the pattern in the 32 bits above it. Bits 511:473 are carried unchanged.
- R3: A fill is a read request (mem_req_write=0) at tbl_base + set*64.
- R4: A lookup whose set is held on chip and whose tag matches gives rsp_hit=1 with the stored pattern and makes no memory request. rsp_valid is high for exactly one cycle, in the third cycle after the accepting edge.
- R5: A lookup with no tag match in its set gives rsp_hit=0 and rsp_pattern=0, and leaves the stored entries unchanged.
- R6: An update whose tag matches replaces that way's pattern in place. It responds with rsp_hit=1 and the previous pattern, and later lookups return the new pattern.
- R7: An update with no tag match writes its tag and pattern into the least recently used way of the set. After a fill, way 0 ranks oldest and way 10 newest; every hit or update makes its way the newest. The response is rsp_hit=0 and rsp_pattern=0.
- R8: Evicting a dirty slot first writes its full 64-byte block to tbl_base + old_set*64, and only then issues the fill read.
- R9: Evicting a clean or empty slot issues no write.
- R10: Only one request is in flight. req_ready stays low from the accepting edge until the response cycle, and a memory request holds its valid, address and write flag until mem_req_ready.
- R11: On a miss, the on-chip slot that is replaced follows a round-robin pointer over the eight slots, starting at slot 0 after reset.
- R12: During and right after reset, req_ready=1, mem_req_valid=0 and rsp_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | 40 | Physical start address of this core's table |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Proxy can accept a request |
| req_pc | input | 16 | Trigger PC bits |
| req_off | input | 5 | Block offset within the spatial region |
| req_write | input | 1 | 1 = update with req_pattern, 0 = lookup |
| req_pattern | input | 32 | Pattern to store on update |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Tag was found in the set |
| rsp_pattern | output | 32 | Stored (lookup) or previous (update) pattern, 0 on miss |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory port accepts the request |
| mem_req_write | output | 1 | 1 = write-back, 0 = fill read |
| mem_req_addr | output | 40 | Block address of the request |
| mem_req_wdata | output | 512 | Packed block for write-back |
| mem_rsp_valid | input | 1 | Fill data valid |
| mem_rsp_data | input | 512 | Packed block returned by a fill |

## Verification
The bench drives lookups and updates in several patterns:
- A cold lookup separates the memory fill path from the on-chip path, checking the fill address and the unpacking of a way in the middle of the block.
- Repeated lookups to the same set, with a matching tag and then a foreign tag, show that hits and tag misses are served without memory traffic and with the fixed three-cycle response.
- A chain of update hits and misses confirms both the in-place replacement and the LRU victim order (way 0, then way 1). The chain also touches other ways, so a victim choice that ignores recency gives a different block.
- A sweep over nine further sets forces one dirty eviction and several clean ones. The bench compares the written-back block bit for bit against a model and checks the write-before-read order, which slot goes next, and that the written-back data persists on a later re-fill.

// File: rtl/pv_proxy_pkg.sv
package pv_proxy_pkg;
    localparam int PV_PC_W   = 16;
    localparam int PV_OFF_W  = 5;
    localparam int PV_SET_W  = 10;
    localparam int PV_TAG_W  = 11;
    localparam int PV_PAT_W  = 32;
    localparam int PV_WAYS   = 11;
    localparam int PV_BLK_W  = 512;
    localparam int PV_SLOTS  = 8;
    localparam int PV_ADDR_W = 40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_WRBACK,
        ST_FILLREQ,
        ST_FILLWAIT,
        ST_SERVE,
        ST_RESP
    } pv_state_e;
endpackage

// File: rtl/pv_set_match.sv
module pv_set_match #(
    parameter int TAG_W = 11,
    parameter int PAT_W = 32,
    parameter int WAYS  = 11,
    parameter int BLK_W = 512,
    parameter int WAY_W = 4
) (
    input  logic [BLK_W-1:0] line,
    input  logic [TAG_W-1:0] tag,
    output logic             hit,
    output logic [WAY_W-1:0] way,
    output logic [PAT_W-1:0] pattern
);
    localparam int ENT_W = TAG_W + PAT_W;

    logic [WAYS-1:0] eq;

    // One tag comparator per packed entry
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign eq[g] = (line[g*ENT_W +: TAG_W] == tag);
    end

    always_comb begin
        hit     = 1'b0;
        way     = '0;
        pattern = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (!hit && eq[i]) begin
                hit     = 1'b1;
                way     = WAY_W'(i);
                pattern = line[i*ENT_W+TAG_W +: PAT_W];
            end
        end
    end
endmodule

// File: rtl/pv_lru_victim.sv
module pv_lru_victim #(
    parameter int WAYS  = 11,
    parameter int AGE_W = 4,
    parameter int WAY_W = 4
) (
    input  logic [WAYS-1:0][AGE_W-1:0] ages,
    output logic [WAY_W-1:0]           victim
);
    logic [AGE_W-1:0] best;

    // Oldest entry has the largest age rank; ties go to the lower way
    always_comb begin
        victim = '0;
        best   = ages[0];
        for (int i = 1; i < WAYS; i++) begin
            if (ages[i] > best) begin
                best   = ages[i];
                victim = WAY_W'(i);
            end
        end
    end
endmodule

// File: rtl/pv_addr_gen.sv
module pv_addr_gen #(
    parameter int ADDR_W    = 40,
    parameter int SET_W     = 10,
    parameter int BLK_OFF_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [SET_W-1:0]  set_idx,
    output logic [ADDR_W-1:0] addr
);
    assign addr = base + ADDR_W'({set_idx, {BLK_OFF_W{1'b0}}});
endmodule

// File: rtl/pv_table_proxy.sv
module pv_table_proxy
    import pv_proxy_pkg::*;
#(
    parameter int PC_W   = PV_PC_W,
    parameter int OFF_W  = PV_OFF_W,
    parameter int SET_W  = PV_SET_W,
    parameter int PAT_W  = PV_PAT_W,
    parameter int WAYS   = PV_WAYS,
    parameter int BLK_W  = PV_BLK_W,
    parameter int SLOTS  = PV_SLOTS,
    parameter int ADDR_W = PV_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_write,
    input  logic [PAT_W-1:0]  req_pattern,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PAT_W-1:0]  rsp_pattern,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [BLK_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [BLK_W-1:0]  mem_rsp_data
);
    localparam int IDX_W     = PC_W + OFF_W;
    localparam int TAG_W     = IDX_W - SET_W;
    localparam int ENT_W     = TAG_W + PAT_W;
    localparam int WAY_W     = $clog2(WAYS);
    localparam int AGE_W     = $clog2(WAYS);
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int BLK_OFF_W = $clog2(BLK_W / 8);

    pv_state_e state_q, state_d;

    // Request captured at acceptance
    logic [IDX_W-1:0]  req_idx;
    logic [SET_W-1:0]  cur_set;
    logic [TAG_W-1:0]  cur_tag;
    logic              cur_write;
    logic [PAT_W-1:0]  cur_pat;
    logic [SLOT_W-1:0] cur_slot;
    logic [SLOT_W-1:0] rr_q;
    logic              rsp_hit_q;
    logic [PAT_W-1:0]  rsp_pat_q;

    // On-chip set store
    logic [BLK_W-1:0]            line_q [SLOTS];
    logic [SET_W-1:0]            sset_q [SLOTS];
    logic [WAYS-1:0][AGE_W-1:0]  age_q  [SLOTS];
    logic [SLOTS-1:0]            vld_q, dty_q;

    assign req_idx = {req_pc, req_off};

    // Set-store probe
    logic [SLOTS-1:0]  slot_eq;
    logic              probe_hit;
    logic [SLOT_W-1:0] probe_slot;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_eq[s] = vld_q[s] && (sset_q[s] == cur_set);
    end

    always_comb begin
        probe_hit  = 1'b0;
        probe_slot = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!probe_hit && slot_eq[s]) begin
                probe_hit  = 1'b1;
                probe_slot = SLOT_W'(s);
            end
        end
    end

    // Entry match and replacement choice on the selected slot
    logic             sm_hit;
    logic [WAY_W-1:0] sm_way;
    logic [PAT_W-1:0] sm_pat;
    logic [WAY_W-1:0] lru_way;
    logic [WAY_W-1:0] wr_way;
    logic             touch_en;
    logic [WAYS-1:0][AGE_W-1:0] ages_cur, ages_new;

    pv_set_match #(
        .TAG_W(TAG_W), .PAT_W(PAT_W), .WAYS(WAYS), .BLK_W(BLK_W), .WAY_W(WAY_W)
    ) u_match (
        .line(line_q[cur_slot]), .tag(cur_tag),
        .hit(sm_hit), .way(sm_way), .pattern(sm_pat)
    );

    assign ages_cur = age_q[cur_slot];

    pv_lru_victim #(
        .WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)
    ) u_lru (
        .ages(ages_cur), .victim(lru_way)
    );

    assign wr_way   = sm_hit ? sm_way : lru_way;
    assign touch_en = cur_write || sm_hit;

    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            if (WAY_W'(i) == wr_way)
                ages_new[i] = '0;
            else if (ages_cur[i] < ages_cur[wr_way])
                ages_new[i] = ages_cur[i] + 1'b1;
            else
                ages_new[i] = ages_cur[i];
        end
    end

    // Block addresses
    logic [ADDR_W-1:0] wb_addr, fill_addr;

    pv_addr_gen #(.ADDR_W(ADDR_W), .SET_W(SET_W), .BLK_OFF_W(BLK_OFF_W)) u_wb_addr (
        .base(tbl_base), .set_idx(sset_q[cur_slot]), .addr(wb_addr)
    );
    pv_addr_gen #(.ADDR_W(ADDR_W), .SET_W(SET_W), .BLK_OFF_W(BLK_OFF_W)) u_fill_addr (
        .base(tbl_base), .set_idx(cur_set), .addr(fill_addr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_PROBE;
            ST_PROBE: begin
                if (probe_hit)                state_d = ST_SERVE;
                else if (vld_q[rr_q] && dty_q[rr_q]) state_d = ST_WRBACK;
                else                          state_d = ST_FILLREQ;
            end
            ST_WRBACK:   if (mem_req_ready) state_d = ST_FILLREQ;
            ST_FILLREQ:  if (mem_req_ready) state_d = ST_FILLWAIT;
            ST_FILLWAIT: if (mem_rsp_valid) state_d = ST_SERVE;
            ST_SERVE:    state_d = ST_RESP;
            ST_RESP:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = fill_addr;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_WRBACK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = wb_addr;
            end
            ST_FILLREQ: mem_req_valid = 1'b1;
            ST_RESP:    rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign mem_req_wdata = line_q[cur_slot];
    assign rsp_hit       = rsp_hit_q;
    assign rsp_pattern   = rsp_pat_q;

    // Control and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q     <= '0;
            dty_q     <= '0;
            rr_q      <= '0;
            cur_set   <= '0;
            cur_tag   <= '0;
            cur_write <= 1'b0;
            cur_pat   <= '0;
            cur_slot  <= '0;
            rsp_hit_q <= 1'b0;
            rsp_pat_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    cur_set   <= req_idx[SET_W-1:0];
                    cur_tag   <= req_idx[IDX_W-1:SET_W];
                    cur_write <= req_write;
                    cur_pat   <= req_pattern;
                end
                ST_PROBE: begin
                    if (probe_hit) begin
                        cur_slot <= probe_slot;
                    end else begin
                        cur_slot <= rr_q;
                        rr_q     <= (rr_q == SLOT_W'(SLOTS-1)) ? '0 : rr_q + 1'b1;
                    end
                end
                ST_FILLWAIT: if (mem_rsp_valid) begin
                    vld_q[cur_slot] <= 1'b1;
                    dty_q[cur_slot] <= 1'b0;
                end
                ST_SERVE: begin
                    rsp_hit_q <= sm_hit;
                    rsp_pat_q <= sm_hit ? sm_pat : '0;
                    if (cur_write) dty_q[cur_slot] <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Set storage
    always_ff @(posedge clk) begin
        if (state_q == ST_FILLWAIT && mem_rsp_valid) begin
            line_q[cur_slot] <= mem_rsp_data;
            sset_q[cur_slot] <= cur_set;
            for (int i = 0; i < WAYS; i++)
                age_q[cur_slot][i] <= AGE_W'(WAYS - 1 - i);
        end else if (state_q == ST_SERVE) begin
            if (touch_en) age_q[cur_slot] <= ages_new;
            for (int w = 0; w < WAYS; w++) begin
                if (cur_write && WAY_W'(w) == wr_way)
                    line_q[cur_slot][w*ENT_W +: ENT_W] <= {cur_pat, cur_tag};
            end
        end
    end
endmodule

// File: rtl/pv_table_proxy_chk.sv
module pv_table_proxy_chk #(
    parameter int ADDR_W = 40,
    parameter int PAT_W  = 32,
    parameter int SET_W  = 10,
    parameter int BLK_W  = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] tbl_base,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PAT_W-1:0]  rsp_pattern,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr
);
    localparam int BLK_OFF_W   = $clog2(BLK_W / 8);
    localparam int TABLE_BYTES = (1 << SET_W) * (BLK_W / 8);

    logic [ADDR_W-1:0] tbl_off;
    assign tbl_off = mem_req_addr - tbl_base;

    // R10: no new request while memory traffic is pending
    a_r10_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R10: memory request held until accepted
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

    // R3: every block address is aligned and inside the table range
    a_r3_addr_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (tbl_off < ADDR_W'(TABLE_BYTES)) &&
                          (tbl_off[BLK_OFF_W-1:0] == '0));

    // R8: a write-back is followed directly by the fill read
    a_r8_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready && mem_req_write |=>
            mem_req_valid && !mem_req_write);

    // R5: a miss carries a zero pattern
    a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> rsp_pattern == '0);

    // R4: response is a single-cycle strobe
    a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: acceptance closes the request port and no response is immediate
    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && !rsp_valid);
endmodule

bind pv_table_proxy pv_table_proxy_chk #(
    .ADDR_W(ADDR_W), .PAT_W(PAT_W), .SET_W(SET_W), .BLK_W(BLK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pattern(rsp_pattern),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr)
);

// File: tb/pv_table_proxy_test.sv
`timescale 1ns/100ps
module pv_table_proxy_test;
    localparam logic [39:0] BASE = 40'h12_3400_0000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_ready, req_write;
    logic [15:0]  req_pc;
    logic [4:0]   req_off;
    logic [31:0]  req_pattern;
    logic         rsp_valid, rsp_hit;
    logic [31:0]  rsp_pattern;
    logic         mem_req_valid, mem_req_write;
    logic         mem_req_ready = 1'b1;
    logic [39:0]  mem_req_addr;
    logic [511:0] mem_req_wdata;
    logic         mem_rsp_valid;
    logic [511:0] mem_rsp_data;

    always #2.5 clk = ~clk;

    pv_table_proxy uut (
        .clk(clk), .rst_n(rst_n), .tbl_base(BASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc),
        .req_off(req_off), .req_write(req_write), .req_pattern(req_pattern),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pattern(rsp_pattern),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // ---------------- memory model ----------------
    logic [511:0] mem [1024];
    int           rd_cnt = 0, wr_cnt = 0;
    logic [39:0]  last_rd_addr, last_wr_addr;
    logic [511:0] last_wr_data;
    bit           ev_is_wr [64];
    int           ev_n = 0;
    bit           pend = 0;
    int           pend_dly = 0;
    int           pend_idx = 0;
    int           rsp_delay = 3;

    function automatic logic [10:0] tag_of(int k, int w);
        return 11'((k + w * 97) & 11'h7ff);
    endfunction

    function automatic logic [31:0] pat_of(int k, int w);
        return 32'hA500_0000 ^ (32'(k) << 8) ^ 32'(w);
    endfunction

    function automatic logic [511:0] blk_init(int k);
        logic [511:0] b = '0;
        for (int i = 0; i < 11; i++) b[i*43 +: 43] = {pat_of(k, i), tag_of(k, i)};
        return b;
    endfunction

    always @(posedge clk) begin
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (ev_n < 64) ev_is_wr[ev_n] = mem_req_write;
            ev_n++;
            if (mem_req_write) begin
                wr_cnt++;
                last_wr_addr = mem_req_addr;
                last_wr_data = mem_req_wdata;
                mem[int'((mem_req_addr - BASE) >> 6) % 1024] = mem_req_wdata;
            end else begin
                rd_cnt++;
                last_rd_addr = mem_req_addr;
                pend     = 1;
                pend_dly = rsp_delay;
                pend_idx = int'((mem_req_addr - BASE) >> 6) % 1024;
            end
        end
    end

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (pend_dly == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[pend_idx];
                pend = 0;
            end else begin
                pend_dly--;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one request and wait for the response; reports hit, pattern, latency
    task automatic do_req(input int set, input logic [10:0] tag, input bit wr,
                          input logic [31:0] pat, output bit hit,
                          output logic [31:0] rpat, output int lat,
                          output bit stall_bad);
        logic [20:0] idx;
        idx = {tag, 10'(set)};
        req_pc      = idx[20:5];
        req_off     = idx[4:0];
        req_write   = wr;
        req_pattern = pat;
        req_valid   = 1'b1;
        lat = 0;
        stall_bad = 0;
        while (1) begin
            @(negedge clk);
            lat++;
            if (lat == 1) req_valid = 1'b0;
            if (rsp_valid) break;
            if (req_ready) stall_bad = 1;
            if (lat > 300) break;
        end
        hit  = rsp_hit;
        rpat = rsp_pattern;
        @(negedge clk);
        chk(!rsp_valid, "R4 strobe one cycle", 512'(rsp_valid), 512'(0));
    endtask

    bit          h;
    logic [31:0] p;
    int          lat;
    bit          sb;
    int          rd0, wr0;
    logic [511:0] exp5;
    localparam logic [31:0] P_NEW = 32'hDEAD_BEEF;
    localparam logic [31:0] Q1    = 32'h1234_5678;
    localparam logic [31:0] Q2    = 32'h0BAD_F00D;
    localparam int          X_TAG = 1945;
    localparam int          Y_TAG = 2042;

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(req_ready === 1'b1, "R12 req_ready", 512'(req_ready), 512'(1));
        chk(mem_req_valid === 1'b0, "R12 mem_req_valid", 512'(mem_req_valid), 512'(0));
        chk(rsp_valid === 1'b0, "R12 rsp_valid", 512'(rsp_valid), 512'(0));
    endtask

    task automatic t_cold_fill();
        do_req(5, tag_of(5, 3), 0, '0, h, p, lat, sb);
        chk(rd_cnt == 1, "R3 one fill read", 512'(rd_cnt), 512'(1));
        chk(last_rd_addr == BASE + 40'(5*64), "R3 fill address", 512'(last_rd_addr),
            512'(BASE + 40'(320)));
        chk(wr_cnt == 0, "R9 no write on empty slot", 512'(wr_cnt), 512'(0));
        chk(h && p == pat_of(5, 3), "R1 R2 unpacked way 3", 512'(p), 512'(pat_of(5, 3)));
        chk(!sb, "R10 ready low during miss", 512'(sb), 512'(0));
    endtask

    task automatic t_cached_hit();
        rd0 = rd_cnt;
        do_req(5, tag_of(5, 7), 0, '0, h, p, lat, sb);
        chk(h && p == pat_of(5, 7), "R4 cached hit pattern", 512'(p), 512'(pat_of(5, 7)));
        chk(lat == 3, "R4 hit latency", 512'(lat), 512'(3));
        chk(rd_cnt == rd0, "R4 no memory read on hit", 512'(rd_cnt), 512'(rd0));
    endtask

    task automatic t_tag_miss();
        rd0 = rd_cnt;
        do_req(5, 11'(X_TAG), 0, '0, h, p, lat, sb);
        chk(!h && p == 0, "R5 tag miss result", 512'({h, p}), 512'(0));
        chk(lat == 3 && rd_cnt == rd0, "R5 served on chip", 512'(lat), 512'(3));
    endtask

    task automatic t_update_hit();
        do_req(5, tag_of(5, 3), 1, P_NEW, h, p, lat, sb);
        chk(h && p == pat_of(5, 3), "R6 update returns old pattern", 512'(p),
            512'(pat_of(5, 3)));
        do_req(5, tag_of(5, 3), 0, '0, h, p, lat, sb);
        chk(h && p == P_NEW, "R6 new pattern visible", 512'(p), 512'(P_NEW));
    endtask

    task automatic t_update_lru();
        do_req(5, 11'(X_TAG), 1, Q1, h, p, lat, sb);
        chk(!h && p == 0, "R7 update miss result", 512'({h, p}), 512'(0));
        do_req(5, tag_of(5, 0), 0, '0, h, p, lat, sb);
        chk(!h, "R7 way 0 replaced first", 512'(h), 512'(0));
        do_req(5, 11'(X_TAG), 0, '0, h, p, lat, sb);
        chk(h && p == Q1, "R7 inserted entry readable", 512'(p), 512'(Q1));
        do_req(5, 11'(Y_TAG), 1, Q2, h, p, lat, sb);
        do_req(5, tag_of(5, 1), 0, '0, h, p, lat, sb);
        chk(!h, "R7 way 1 replaced second", 512'(h), 512'(0));
        do_req(5, tag_of(5, 2), 0, '0, h, p, lat, sb);
        chk(h && p == pat_of(5, 2), "R7 way 2 kept", 512'(p), 512'(pat_of(5, 2)));
    endtask

    task automatic t_dirty_evict();
        exp5 = blk_init(5);
        exp5[3*43 +: 43] = {P_NEW, tag_of(5, 3)};
        exp5[0*43 +: 43] = {Q1, 11'(X_TAG)};
        exp5[1*43 +: 43] = {Q2, 11'(Y_TAG)};
        for (int k = 6; k <= 12; k++) do_req(k, tag_of(k, 0), 0, '0, h, p, lat, sb);
        chk(wr_cnt == 0, "R9 clean fills write nothing", 512'(wr_cnt), 512'(0));
        rd0 = rd_cnt;
        ev_n = 0;
        do_req(13, tag_of(13, 4), 0, '0, h, p, lat, sb);
        chk(wr_cnt == 1, "R8 one write-back", 512'(wr_cnt), 512'(1));
        chk(last_wr_addr == BASE + 40'(320), "R8 write-back address", 512'(last_wr_addr),
            512'(BASE + 40'(320)));
        chk(last_wr_data == exp5, "R2 R6 R8 written-back block", last_wr_data, exp5);
        chk(ev_n == 2 && ev_is_wr[0] && !ev_is_wr[1], "R8 write before read",
            512'({ev_is_wr[0], ev_is_wr[1]}), 512'(2'b10));
        chk(h && p == pat_of(13, 4), "R11 slot 0 reused for set 13", 512'(p),
            512'(pat_of(13, 4)));
        chk(!sb, "R10 ready low during write-back", 512'(sb), 512'(0));
    endtask

    task automatic t_clean_evict_rr();
        wr0 = wr_cnt;
        rd0 = rd_cnt;
        do_req(14, tag_of(14, 9), 0, '0, h, p, lat, sb);
        chk(wr_cnt == wr0 && rd_cnt == rd0 + 1, "R9 clean eviction no write",
            512'(wr_cnt), 512'(wr0));
        do_req(7, tag_of(7, 0), 0, '0, h, p, lat, sb);
        chk(rd_cnt == rd0 + 1 && lat == 3, "R11 slot 2 untouched", 512'(rd_cnt),
            512'(rd0 + 1));
        do_req(6, tag_of(6, 0), 0, '0, h, p, lat, sb);
        chk(rd_cnt == rd0 + 2, "R11 slot 1 was replaced", 512'(rd_cnt), 512'(rd0 + 2));
        do_req(5, 11'(X_TAG), 0, '0, h, p, lat, sb);
        chk(h && p == Q1, "R8 written-back entry persists", 512'(p), 512'(Q1));
        chk(last_rd_addr == BASE + 40'(320), "R3 refill address", 512'(last_rd_addr),
            512'(BASE + 40'(320)));
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) mem[k] = blk_init(k);
        rst_n = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_pc = '0; req_off = '0; req_pattern = '0;
        mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_fill();
        t_cached_hit();
        t_tag_miss();
        t_update_hit();
        t_update_lru();
        t_dirty_evict();
        t_clean_evict_rr();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule